// File: doc/BRIEF.md
# Power and Sleep Controller Register Block

This block is a memory-mapped slave that manages a set of power domains and the gated modules that live in them. Software writes a desired next state for each module and a power-on request for each domain into control registers. Nothing changes until software issues a per-domain go command. The domain's transition engine then moves every module of that domain to its requested state after a fixed latency. Status registers and two output pins per module report the result: a clock-enable pin and an active-high local-reset pin.

Sometimes a go command arrives for a domain that is powered off while that domain's control register asks for power. In that case the engine first raises the domain's bit in the external power request register. It then stalls until software confirms power-good in the domain control register, and only after that does it run the module transition. Module m belongs to domain m modulo the number of domains. Each bus access completes with a one-cycle ready pulse.

Top module: `psc_top`

## Requirements
- R1: After reset, every module is in state 0 (software-reset-disable), its control register reads 0x0000_0100, every clock-enable output is 0, and every local-reset output is 1. The domain status, domain control, transition status and external power request registers all read 0.
- R2: Module control n sits at 0xA00+4n. Bits 1:0 hold the next state, bit 8 the local-reset release bit and bit 31 the force flag; bits 5:2 read as 0. Domain control n sits at 0x300+4n, with bit 0 as the power-on request and bit 8 as power-good. Both read back what was written in those fields, and all other bits read as 0.
- R3: A bus access is held for one cycle with bus_sel high. bus_ready is high in the following cycle only, and for a read bus_rdata is valid in that same cycle.
- R4: Writing 1 to bit n of the command register (0x120) while domain n is powered sets bit n of the transition status register (0x128). Each module of the domain takes its requested state on the 8th clock edge after the write edge, and the status bit clears on that same edge.
- R5: A write to a module control register alone never changes the module's current state, its status register or its clock-enable output.
- R6: If domain n is off (domain status 0x200+4n reads 0) and its power-on bit is set, a go command sets bit n of the external power request register (0x070). The engine then stalls with no module change until power-good is set. After that the request bit clears, domain status reads 1 and the transition completes.
- R7: A module's clock-enable output and bit 12 of its status register (0x800+4n) are 1 exactly when its current state is 3 (enable). Bits 5:0 of that status register report the current state.
- R8: The local-reset output of a module is 1 when its control bit 8 is 0 or its current state is 0 or 1, and 0 otherwise. It follows a control write without any go command.
- R9: A go command for a domain whose transition is still in progress is ignored and does not restart the latency count.
- R10: Reads of unmapped addresses, including domain or module indices beyond the configured counts and the command register itself, return 0. Writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | Access strobe, one cycle per access |
| bus_we | input | 1 | 1 for write, 0 for read |
| bus_addr | input | 12 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid with bus_ready |
| bus_ready | output | 1 | Access completion, one cycle after bus_sel |
| mod_clk_en | output | N_MOD | Per-module clock enable |
| mod_lrst | output | N_MOD | Per-module local reset, active high |

## Verification
The hardest situation to reach is a second go command that lands while the same domain is still counting toward its update. A restart of the count would be invisible unless the clock-enable pin is sampled on the exact cycles where an unrestarted transition must have finished. The bench issues the first command and waits three cycles to issue the second. It then checks the module pin one cycle before and on the eighth edge after the first command. The power handshake stall is reached the same way: the bench holds back power-good for many cycles and confirms that neither the pins nor the request bit move.

// File: rtl/psc_pkg.sv
// Shared constants and types for the power and sleep controller.
// Assumes a 12-bit byte address space with word-aligned registers.
package psc_pkg;
    localparam int ADDR_W = 12;
    localparam int DATA_W = 32;
    localparam int IDX_W  = 6;

    localparam logic [ADDR_W-1:0] OFF_EPWR   = 12'h070;
    localparam logic [ADDR_W-1:0] OFF_GO     = 12'h120;
    localparam logic [ADDR_W-1:0] OFF_BUSY   = 12'h128;
    localparam logic [3:0]        RGN_DSTAT  = 4'h2;
    localparam logic [3:0]        RGN_DCTL   = 4'h3;
    localparam logic [3:0]        RGN_MSTAT  = 4'h8;
    localparam logic [3:0]        RGN_MCTL   = 4'hA;

    typedef enum logic [1:0] {
        MS_SWRST_OFF = 2'd0,
        MS_SYNC_RST  = 2'd1,
        MS_OFF       = 2'd2,
        MS_ON        = 2'd3
    } mod_state_e;

    typedef enum logic [1:0] {
        ENG_IDLE = 2'd0,
        ENG_WAIT = 2'd1,
        ENG_RUN  = 2'd2
    } eng_state_e;
endpackage

// File: rtl/psc_mod_slot.sv
// One gated module: holds its staged control fields and its current state.
// Assumes apply is a one-cycle pulse from the owning domain's engine.
module psc_mod_slot
    import psc_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        ctl_we,
    input  logic [1:0]  wr_next,
    input  logic        wr_force,
    input  logic        wr_lrel,
    input  logic        apply,
    output logic [31:0] ctl_word,
    output logic [31:0] stat_word,
    output logic        clk_en,
    output logic        lrst
);
    logic [1:0] nxt_q;
    logic       force_q;
    logic       lrel_q;
    mod_state_e state_q;

    // Control register: staged next state, force flag, reset release.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            nxt_q   <= 2'd0;
            force_q <= 1'b0;
            lrel_q  <= 1'b1;
        end else if (ctl_we) begin
            nxt_q   <= wr_next;
            force_q <= wr_force;
            lrel_q  <= wr_lrel;
        end
    end

    // Current state: only the domain engine's apply pulse moves it.
    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= MS_SWRST_OFF;
        else if (apply)
            state_q <= mod_state_e'(nxt_q);
    end

    // Outputs and register images.
    always_comb begin
        clk_en    = (state_q == MS_ON);
        lrst      = !lrel_q || (state_q == MS_SWRST_OFF) || (state_q == MS_SYNC_RST);
        ctl_word  = {force_q, 22'd0, lrel_q, 6'd0, nxt_q};
        stat_word = {19'd0, clk_en, 10'd0, state_q};
    end
endmodule

// File: rtl/psc_dom_engine.sv
// One power domain: control register, power state and transition engine.
// Assumes go is a one-cycle pulse; a go while busy is dropped.
module psc_dom_engine
    import psc_pkg::*;
#(
    parameter int LATENCY = 8
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        ctl_we,
    input  logic        wr_on,
    input  logic        wr_pgood,
    input  logic        go,
    output logic [31:0] ctl_word,
    output logic        pgood,
    output logic        busy,
    output logic        ep_req,
    output logic        dom_on,
    output logic        apply
);
    localparam int CNT_W = $clog2(LATENCY + 1);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(LATENCY - 1);

    logic       on_q;
    logic       pgood_q;
    eng_state_e st_q;
    logic [CNT_W-1:0] cnt_q;

    // Domain control register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            on_q    <= 1'b0;
            pgood_q <= 1'b0;
        end else if (ctl_we) begin
            on_q    <= wr_on;
            pgood_q <= wr_pgood;
        end
    end

    // Transition engine: optional power handshake, then a fixed count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= ENG_IDLE;
            cnt_q  <= '0;
            ep_req <= 1'b0;
            dom_on <= 1'b0;
        end else begin
            case (st_q)
                ENG_IDLE: if (go) begin
                    cnt_q <= '0;
                    if (!dom_on && on_q) begin
                        ep_req <= 1'b1;
                        st_q   <= ENG_WAIT;
                    end else begin
                        st_q   <= ENG_RUN;
                    end
                end
                ENG_WAIT: if (pgood_q) begin
                    ep_req <= 1'b0;
                    dom_on <= 1'b1;
                    st_q   <= ENG_RUN;
                end
                ENG_RUN: begin
                    if (cnt_q == CNT_LAST)
                        st_q <= ENG_IDLE;
                    else
                        cnt_q <= cnt_q + 1'b1;
                end
                default: st_q <= ENG_IDLE;
            endcase
        end
    end

    // Status views.
    always_comb begin
        busy     = (st_q != ENG_IDLE);
        apply    = (st_q == ENG_RUN) && (cnt_q == CNT_LAST);
        pgood    = pgood_q;
        ctl_word = {23'd0, pgood_q, 7'd0, on_q};
    end
endmodule

// File: rtl/psc_top.sv
// Power and sleep controller: register decode, read mux and the arrays
// of domain engines and module slots. Module m belongs to domain m % N_DOM.
// Assumes N_DOM <= 32 and N_MOD <= 64.
module psc_top
    import psc_pkg::*;
#(
    parameter int N_DOM   = 2,
    parameter int N_MOD   = 4,
    parameter int LATENCY = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              bus_ready,
    output logic [N_MOD-1:0]  mod_clk_en,
    output logic [N_MOD-1:0]  mod_lrst
);
    logic [3:0]       region;
    logic [IDX_W-1:0] idx;
    logic             aligned;
    logic             wr;
    logic [DATA_W-1:0] rd_mux;

    logic [N_DOM-1:0] dom_busy, dom_apply, dom_ep, dom_on, dom_pgood, dom_go, dom_wr;
    logic [N_MOD-1:0] mod_wr;
    logic [31:0] dom_ctl_w [N_DOM];
    logic [31:0] mod_ctl_w [N_MOD];
    logic [31:0] mod_stat_w [N_MOD];
    logic unused_wdata;

    assign region  = bus_addr[11:8];
    assign idx     = bus_addr[7:2];
    assign aligned = (bus_addr[1:0] == 2'b00);
    assign wr      = bus_sel && bus_we && aligned;
    assign unused_wdata = ^bus_wdata;

    genvar gd, gm;
    generate
        for (gd = 0; gd < N_DOM; gd++) begin : g_dom
            assign dom_wr[gd] = wr && (region == RGN_DCTL) && (idx == IDX_W'(gd));
            assign dom_go[gd] = wr && (bus_addr == OFF_GO) && bus_wdata[gd];
            psc_dom_engine #(.LATENCY(LATENCY)) u_eng (
                .clk      (clk),
                .rst_n    (rst_n),
                .ctl_we   (dom_wr[gd]),
                .wr_on    (bus_wdata[0]),
                .wr_pgood (bus_wdata[8]),
                .go       (dom_go[gd]),
                .ctl_word (dom_ctl_w[gd]),
                .pgood    (dom_pgood[gd]),
                .busy     (dom_busy[gd]),
                .ep_req   (dom_ep[gd]),
                .dom_on   (dom_on[gd]),
                .apply    (dom_apply[gd])
            );
        end
        for (gm = 0; gm < N_MOD; gm++) begin : g_mod
            assign mod_wr[gm] = wr && (region == RGN_MCTL) && (idx == IDX_W'(gm));
            psc_mod_slot u_slot (
                .clk       (clk),
                .rst_n     (rst_n),
                .ctl_we    (mod_wr[gm]),
                .wr_next   (bus_wdata[1:0]),
                .wr_force  (bus_wdata[31]),
                .wr_lrel   (bus_wdata[8]),
                .apply     (dom_apply[gm % N_DOM]),
                .ctl_word  (mod_ctl_w[gm]),
                .stat_word (mod_stat_w[gm]),
                .clk_en    (mod_clk_en[gm]),
                .lrst      (mod_lrst[gm])
            );
        end
    endgenerate

    // Read mux: unmapped or out-of-range addresses return zero.
    always_comb begin
        rd_mux = '0;
        if (aligned) begin
            if (bus_addr == OFF_EPWR)
                rd_mux = DATA_W'(dom_ep);
            else if (bus_addr == OFF_BUSY)
                rd_mux = DATA_W'(dom_busy);
            else begin
                for (int d = 0; d < N_DOM; d++) begin
                    if (idx == IDX_W'(d) && region == RGN_DSTAT) rd_mux = DATA_W'(dom_on[d]);
                    if (idx == IDX_W'(d) && region == RGN_DCTL)  rd_mux = dom_ctl_w[d];
                end
                for (int m = 0; m < N_MOD; m++) begin
                    if (idx == IDX_W'(m) && region == RGN_MSTAT) rd_mux = mod_stat_w[m];
                    if (idx == IDX_W'(m) && region == RGN_MCTL)  rd_mux = mod_ctl_w[m];
                end
            end
        end
    end

    // Bus response: ready one cycle after the strobe, read data registered.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_ready <= 1'b0;
            bus_rdata <= '0;
        end else begin
            bus_ready <= bus_sel;
            if (bus_sel && !bus_we)
                bus_rdata <= rd_mux;
        end
    end
endmodule

// File: rtl/psc_checker.sv
// Temporal checks on the controller, bound into every psc_top instance.
// Assumes module m is served by domain m % N_DOM.
module psc_checker #(
    parameter int N_DOM = 2,
    parameter int N_MOD = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             bus_sel,
    input logic             bus_ready,
    input logic [N_DOM-1:0] dom_busy,
    input logic [N_DOM-1:0] dom_apply,
    input logic [N_DOM-1:0] dom_ep,
    input logic [N_DOM-1:0] dom_pgood,
    input logic [N_MOD-1:0] mod_clk_en
);
    // R3: every strobe is answered in the next cycle.
    p_ready_after_sel_r3: assert property (@(posedge clk) disable iff (!rst_n)
        bus_sel |=> bus_ready);

    genvar gd, gm;
    generate
        for (gd = 0; gd < N_DOM; gd++) begin : g_d
            // R4: a transition stays pending until its apply pulse.
            p_busy_holds_r4: assert property (@(posedge clk) disable iff (!rst_n)
                dom_busy[gd] && !dom_apply[gd] |=> dom_busy[gd]);
            // R6: power request is only raised inside a transition.
            p_req_in_transition_r6: assert property (@(posedge clk) disable iff (!rst_n)
                dom_ep[gd] |-> dom_busy[gd]);
            // R6: without power-good the request and stall persist.
            p_req_stalls_r6: assert property (@(posedge clk) disable iff (!rst_n)
                dom_ep[gd] && !dom_pgood[gd] |=> dom_ep[gd] && !dom_apply[gd]);
        end
        for (gm = 0; gm < N_MOD; gm++) begin : g_m
            // R5: a module clock only changes right after its domain applies.
            p_clk_moves_on_apply_r5: assert property (@(posedge clk) disable iff (!rst_n)
                !$stable(mod_clk_en[gm]) |-> $past(dom_apply[gm % N_DOM]));
        end
    endgenerate
endmodule

bind psc_top psc_checker #(.N_DOM(N_DOM), .N_MOD(N_MOD)) u_psc_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_sel    (bus_sel),
    .bus_ready  (bus_ready),
    .dom_busy   (dom_busy),
    .dom_apply  (dom_apply),
    .dom_ep     (dom_ep),
    .dom_pgood  (dom_pgood),
    .mod_clk_en (mod_clk_en)
);

// File: tb/tb_psc_top.sv
`timescale 1ns/1ps
// Directed bench for psc_top: one task per scenario, each self-checking.
module tb_psc_top;
    localparam int N_DOM = 2;
    localparam int N_MOD = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_we = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        bus_ready;
    logic [N_MOD-1:0] mod_clk_en;
    logic [N_MOD-1:0] mod_lrst;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    psc_top #(.N_DOM(N_DOM), .N_MOD(N_MOD), .LATENCY(8)) dut (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .bus_ready(bus_ready), .mod_clk_en(mod_clk_en), .mod_lrst(mod_lrst)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    // Called at a negedge; the write lands on the next posedge.
    task automatic bus_write(input logic [11:0] a, input logic [31:0] d);
        bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_we = 1'b0;
    endtask

    task automatic bus_read(input logic [11:0] a, output logic [31:0] d);
        bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
        @(negedge clk);
        d = bus_rdata;
        bus_sel = 1'b0;
    endtask

    task automatic read_chk(input logic [11:0] a, input logic [31:0] exp, input string req);
        logic [31:0] v;
        bus_read(a, v);
        chk(v == exp, req, v, exp);
    endtask

    task automatic wait_idle(input int d);
        logic [31:0] v;
        for (int i = 0; i < 100; i++) begin
            bus_read(12'h128, v);
            if (!v[d]) return;
        end
        chk(1'b0, "R6 transition never completed", v, 32'h0);
    endtask

    task automatic t_reset;
        chk(mod_clk_en == '0, "R1 clk_en", 32'(mod_clk_en), 32'h0);
        chk(mod_lrst == '1, "R1 lrst", 32'(mod_lrst), 32'hF);
        read_chk(12'h128, 32'h0, "R1 busy reg");
        read_chk(12'h070, 32'h0, "R1 power request reg");
        read_chk(12'h800, 32'h0, "R1 module status 0");
        read_chk(12'hA0C, 32'h100, "R1 module control 3");
        read_chk(12'h204, 32'h0, "R1 domain status 1");
        read_chk(12'h300, 32'h0, "R1 domain control 0");
    endtask

    task automatic t_bus_ready;
        logic [31:0] v;
        bus_sel = 1'b1; bus_we = 1'b0; bus_addr = 12'hA00;
        @(negedge clk);
        chk(bus_ready == 1'b1, "R3 ready after strobe", 32'(bus_ready), 32'h1);
        v = bus_rdata;
        chk(v == 32'h100, "R3 data with ready", v, 32'h100);
        bus_sel = 1'b0;
        @(negedge clk);
        chk(bus_ready == 1'b0, "R3 ready single cycle", 32'(bus_ready), 32'h0);
    endtask

    task automatic t_regmap;
        bus_write(12'hA04, 32'h8000_01FF);
        read_chk(12'hA04, 32'h8000_0103, "R2 module control fields");
        bus_write(12'h304, 32'hFFFF_FFFF);
        read_chk(12'h304, 32'h0000_0101, "R2 domain control fields");
    endtask

    task automatic t_staging;
        bus_write(12'hA00, 32'h103);
        repeat (12) @(negedge clk);
        chk(mod_clk_en[0] == 1'b0, "R5 no change without go", 32'(mod_clk_en[0]), 32'h0);
        read_chk(12'h800, 32'h0, "R5 status unchanged");
    endtask

    task automatic t_handshake;
        bus_write(12'h300, 32'h1);
        bus_write(12'h120, 32'h1);
        read_chk(12'h070, 32'h1, "R6 power request raised");
        read_chk(12'h128, 32'h1, "R6 transition pending");
        repeat (20) @(negedge clk);
        chk(mod_clk_en[0] == 1'b0, "R6 stalled without power-good", 32'(mod_clk_en[0]), 32'h0);
        read_chk(12'h070, 32'h1, "R6 request held");
        bus_write(12'h300, 32'h101);
        wait_idle(0);
        chk(mod_clk_en[0] == 1'b1, "R6 module enabled after handshake", 32'(mod_clk_en[0]), 32'h1);
        read_chk(12'h800, 32'h1003, "R7 status state 3 with clock bit");
        read_chk(12'h808, 32'h0, "R7 other module of domain stays 0");
        read_chk(12'h200, 32'h1, "R6 domain now on");
        read_chk(12'h070, 32'h0, "R6 request cleared");
    endtask

    task automatic t_latency;
        bus_write(12'hA08, 32'h103);
        bus_write(12'h120, 32'h1);
        repeat (7) @(negedge clk);
        chk(mod_clk_en[2] == 1'b0, "R4 not yet at 7 cycles", 32'(mod_clk_en[2]), 32'h0);
        @(negedge clk);
        chk(mod_clk_en[2] == 1'b1, "R4 updated at 8 cycles", 32'(mod_clk_en[2]), 32'h1);
        read_chk(12'h128, 32'h0, "R4 busy bit cleared");
    endtask

    task automatic t_go_while_busy;
        bus_write(12'hA08, 32'h102);
        bus_write(12'h120, 32'h1);
        repeat (3) @(negedge clk);
        bus_write(12'h120, 32'h1);
        repeat (3) @(negedge clk);
        chk(mod_clk_en[2] == 1'b1, "R9 still enabled before edge 8", 32'(mod_clk_en[2]), 32'h1);
        @(negedge clk);
        chk(mod_clk_en[2] == 1'b0, "R9 second go did not restart", 32'(mod_clk_en[2]), 32'h0);
        read_chk(12'h128, 32'h0, "R9 no pending transition");
        read_chk(12'h808, 32'h2, "R7 disabled status without clock bit");
    endtask

    task automatic t_local_reset;
        chk(mod_lrst[2] == 1'b0, "R8 released in disable state", 32'(mod_lrst[2]), 32'h0);
        bus_write(12'hA08, 32'h002);
        chk(mod_lrst[2] == 1'b1, "R8 control bit asserts reset", 32'(mod_lrst[2]), 32'h1);
        bus_write(12'hA08, 32'h102);
        chk(mod_lrst[2] == 1'b0, "R8 control bit releases reset", 32'(mod_lrst[2]), 32'h0);
        bus_write(12'hA00, 32'h101);
        bus_write(12'h120, 32'h1);
        wait_idle(0);
        chk(mod_lrst[0] == 1'b1, "R8 sync reset state asserts reset", 32'(mod_lrst[0]), 32'h1);
        chk(mod_clk_en[0] == 1'b0, "R7 clock off in sync reset", 32'(mod_clk_en[0]), 32'h0);
    endtask

    task automatic t_unmapped;
        bus_write(12'h308, 32'hFFFF_FFFF);
        bus_write(12'hA10, 32'hFFFF_FFFF);
        bus_write(12'h000, 32'hFFFF_FFFF);
        read_chk(12'h308, 32'h0, "R10 domain index out of range");
        read_chk(12'hA10, 32'h0, "R10 module index out of range");
        read_chk(12'h120, 32'h0, "R10 command reads zero");
        read_chk(12'hA00, 32'h101, "R10 no alias into module 0");
        read_chk(12'h300, 32'h101, "R10 no alias into domain 0");
        chk(mod_clk_en == 4'b0000, "R10 pins unchanged", 32'(mod_clk_en), 32'h0);
    endtask

    initial begin
        #(200000 * 5);
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_bus_ready();
        t_regmap();
        t_staging();
        t_handshake();
        t_latency();
        t_go_while_busy();
        t_local_reset();
        t_unmapped();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule